// File: doc/BRIEF.md
# Field-Programmable Flip-Flop Match Segment

This block watches a group of eight control flip-flops and reports, every clock cycle, whether their live values fit a signature that can be rewritten after the chip is built. Each watched bit owns a two-bit configuration cell. One bit turns monitoring of that flip-flop on or off. The other gives the value the flip-flop must hold for the signature to fire. A bit whose monitoring is off is a don't-care.

The sixteen configuration bits form one serial chain. They are written one bit per clock while scan-enable is high, through a scan-in pin, and the far end of the chain is visible on scan-out. Once loaded, the segment compares the observed bits with the signature and drives one registered output. The output is 0 when every enabled bit matches and 1 when any enabled bit differs. While the chain is being shifted the output is held at mismatch, so a half-written signature can never report a match.

Top module: `ff_match_segment`

## Requirements
- R1: Each rising clock with `scanEn` high shifts one bit into the chain. A full load takes 16 shifts. The stream order is: monitor-enable of bit 7 first, then expected value of bit 7, then monitor-enable of bit 6, then expected value of bit 6, and so on down to the expected value of bit 0, which is last.
- R2: With `scanEn` low, the configuration and `scanOut` do not change, whatever `scanIn` does.
- R3: `scanOut` always shows the chain bit that entered earliest among the last 16 shifted in. After a full load this is the monitor-enable of bit 7. Further shifting returns the loaded stream in the order it entered.
- R4: With `scanEn` low, `segMiss` is 0 when every enabled bit i has `obsBits[i]` equal to its expected value, and 1 when any enabled bit differs.
- R5: A bit whose monitor-enable is 0 has no effect on `segMiss`.
- R6: `segMiss` is registered. It reflects the `obsBits` and configuration present at the previous rising edge.
- R7: A rising edge with `scanEn` high makes `segMiss` 1 for the following cycle, whatever `obsBits` holds.
- R8: During reset (`rstN` low) every configuration bit clears to 0, `scanOut` is 0 and `segMiss` is 1.
- R9: With every monitor-enable at 0 (as after reset), `segMiss` is 0 after each edge with `scanEn` low, for any `obsBits`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| scanEn | input | 1 | Configuration chain shift enable |
| scanIn | input | 1 | Serial configuration input |
| scanOut | output | 1 | Serial configuration output (chain end) |
| obsBits | input | 8 | Live values of the observed flip-flops |
| segMiss | output | 1 | Registered result: 0 signature matched, 1 mismatch |

## Verification
The compare and the chain shift can fall on the same edge. A shift edge where `obsBits` fits the old signature must still produce a mismatch on the output, while the chain moves by one bit. The bench provokes this in two ways. It asserts `scanEn` directly over a matching pattern. It also runs random cycles that interleave shifts with compares. A queue-based reference that evaluates the compare before the shift judges each cycle on both `segMiss` and `scanOut`.

// File: rtl/segmon_pkg.sv
package segmon_pkg;
  typedef struct packed {
    logic shift;      // advance the configuration chain this edge
    logic forceMiss;  // override the compare result to mismatch
  } segStrobe_t;
endpackage

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import segmon_pkg::*;
(
  input  logic       scanEn,
  output segStrobe_t stb
);
  // Loading and result masking are both tied to the scan enable.
  always_comb begin
    stb.shift     = scanEn;
    stb.forceMiss = scanEn;
  end
endmodule

// File: rtl/seg_cfg_cell.sv
module seg_cfg_cell (
  input  logic clk,
  input  logic rstN,
  input  logic shift,
  input  logic sIn,
  input  logic obsBit,
  output logic cfgEn,
  output logic cfgVal,
  output logic missBit
);
  // Serial path inside the cell: sIn -> cfgVal -> cfgEn -> next cell.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEn  <= 1'b0;
      cfgVal <= 1'b0;
    end else if (shift) begin
      cfgVal <= sIn;
      cfgEn  <= cfgVal;
    end
  end

  assign missBit = cfgEn & (obsBit ^ cfgVal);

  // R1: one bit moves per shift edge
  p_shift_r1: assert property (@(posedge clk) disable iff (!rstN)
    shift |=> (cfgVal == $past(sIn)) && (cfgEn == $past(cfgVal)));

  // R2: configuration holds without shift
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !shift |=> $stable(cfgEn) && $stable(cfgVal));
endmodule

// File: rtl/seg_datapath.sv
module seg_datapath
  import segmon_pkg::*;
#(
  parameter int NUM_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  segStrobe_t          stb,
  input  logic                scanIn,
  input  logic [NUM_BITS-1:0] obsBits,
  output logic                scanOut,
  output logic                missQ
);
  logic [NUM_BITS-1:0] cfgEn;
  logic [NUM_BITS-1:0] cfgVal;
  logic [NUM_BITS-1:0] missVec;
  logic [NUM_BITS-1:0] chainIn;

  // Bit 0 is fed from the pin; each later cell takes its neighbour's enable.
  assign chainIn = {cfgEn[NUM_BITS-2:0], scanIn};

  for (genvar g = 0; g < NUM_BITS; g++) begin : gCell
    seg_cfg_cell uCell (
      .clk     (clk),
      .rstN    (rstN),
      .shift   (stb.shift),
      .sIn     (chainIn[g]),
      .obsBit  (obsBits[g]),
      .cfgEn   (cfgEn[g]),
      .cfgVal  (cfgVal[g]),
      .missBit (missVec[g])
    );
  end

  assign scanOut = cfgEn[NUM_BITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              missQ <= 1'b1;
    else if (stb.forceMiss) missQ <= 1'b1;
    else                    missQ <= |missVec;
  end

  // R7: a shift edge always yields mismatch
  p_force_miss_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.forceMiss |=> missQ);

  // R9: nothing enabled means a match
  p_all_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.forceMiss && (cfgEn == '0)) |=> !missQ);

  // R3: the chain end takes the last cell's value bit on a shift
  p_scan_out_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.shift |=> scanOut == $past(cfgVal[NUM_BITS-1]));
endmodule

// File: rtl/ff_match_segment.sv
module ff_match_segment
  import segmon_pkg::*;
#(
  parameter int NUM_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                scanEn,
  input  logic                scanIn,
  output logic                scanOut,
  input  logic [NUM_BITS-1:0] obsBits,
  output logic                segMiss
);
  segStrobe_t stb;

  seg_ctrl uCtrl (
    .scanEn (scanEn),
    .stb    (stb)
  );

  seg_datapath #(.NUM_BITS(NUM_BITS)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .scanIn  (scanIn),
    .obsBits (obsBits),
    .scanOut (scanOut),
    .missQ   (segMiss)
  );
endmodule

// File: tb/test_ff_match_segment.sv
module test_ff_match_segment;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scanEn = 1'b0;
  logic scanIn = 1'b0;
  logic [N-1:0] obsBits = '0;
  logic scanOut;
  logic segMiss;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit mq[$];      // mq[0] = oldest bit in the chain (at scan out)
  bit expMiss;

  ff_match_segment #(.NUM_BITS(N)) i_ff_match_segment (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .scanIn(scanIn),
    .scanOut(scanOut), .obsBits(obsBits), .segMiss(segMiss)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(logic got, logic exp, string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  // Reference: bit i enable sits at mq[2*(N-1-i)], value just after it.
  function automatic bit refMiss(logic [N-1:0] obs);
    for (int i = 0; i < N; i++) begin
      if (mq[2*(N-1-i)] && (obs[i] != mq[2*(N-1-i)+1])) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic step(bit se, bit si, logic [N-1:0] obs, string tag);
    scanEn = se; scanIn = si; obsBits = obs;
    @(posedge clk);
    expMiss = se ? 1'b1 : refMiss(obs);
    if (se) begin
      void'(mq.pop_front());
      mq.push_back(si);
    end
    @(negedge clk);
    chk(segMiss, expMiss, tag);
    chk(scanOut, mq[0], "R3 scan out");
  endtask

  task automatic loadSig(logic [N-1:0] en, logic [N-1:0] val);
    for (int i = N-1; i >= 0; i--) begin
      step(1'b1, en[i], N'($urandom), "R7 R1 loading");
      step(1'b1, val[i], N'($urandom), "R7 R1 loading");
    end
  endtask

  initial begin
    for (int i = 0; i < W; i++) mq.push_back(1'b0);
    repeat (3) @(negedge clk);
    chk(segMiss, 1'b1, "R8 reset miss");
    chk(scanOut, 1'b0, "R8 reset scan out");
    rstN = 1'b1;

    // R9: empty signature matches anything
    for (int k = 0; k < 6; k++) step(1'b0, 1'($urandom), N'($urandom), "R9 R5 empty");

    // R1: enables on bits 7,5,2,0; bits 7,0 want 1, bits 5,2 want 0
    loadSig(8'hA5, 8'h81);
    step(1'b0, 1'b0, 8'h81, "R1 R4 exact match");
    chk(segMiss, 1'b0, "R1 loaded signature matches");
    step(1'b0, 1'b0, 8'h85, "R4 R6 bit2 mismatch");
    chk(segMiss, 1'b1, "R4 enabled mismatch");
    step(1'b0, 1'b0, 8'h01, "R4 R6 bit7 mismatch");
    step(1'b0, 1'b0, 8'h81, "R6 back to match");

    // R5: toggle only disabled bits (mask 0x5A)
    for (int k = 0; k < 8; k++)
      step(1'b0, 1'($urandom), 8'h81 | (N'($urandom) & 8'h5A), "R5 dont care");

    // R2: scanIn toggles with scanEn low
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 1'(k), 8'h81, "R2 hold");
      chk(scanOut, 1'b1, "R2 scan out held");
    end

    // R7: shift over a matching pattern
    step(1'b1, 1'b0, 8'h81, "R7 shift during match");
    chk(segMiss, 1'b1, "R7 forced miss");

    // R3: shift out a fresh load in order
    loadSig(8'h3C, 8'h14);
    for (int k = 0; k < W; k++) step(1'b1, 1'($urandom), N'($urandom), "R7 R3 unload");

    // mixed traffic
    for (int k = 0; k < 400; k++)
      step(($urandom % 4) == 0, 1'($urandom), N'($urandom), "R4 R6 R7 mixed");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule